// File: doc/BRIEF.md
# Configuration space access port

This block is the indirect configuration-access mechanism for a small bus segment. It is a slave on a simple I/O bus and decodes two 32-bit ports. Software first writes a selector word to the address port. That word names a bus number, a device/function byte and a dword register index. Software then reads the selected configuration dword through the data port, or writes it. Every byte lane of both ports can be written on its own.

A parameterised table of device slots sits behind the ports. Each slot carries a 16-bit bus/devfn identifier and a configuration image of `IMG_DWORDS` dwords, which is loaded at reset from parameters. Each slot also has up to six base-address registers, each with a power-of-two size and two type bits.

The lookup is made only when the top byte of the address port is written. Its result is latched into a response register, and a presence flag records whether a slot matched. Reads of the address port return the presence flag, not the stored selector. Writes to the data port only affect the base-address register dwords.

Top module: `cfg_access_port`

## Requirements
- R1: After reset, the address port reads 0x00000000, the data port reads 0xFFFFFFFF, and every slot image holds its default contents. Slot 0 has identifier 0x0000, dword 0 = 0x5E6F7081 and dword 2 = 0x06000001, with no base registers. Slot 1 has identifier 0x0008, dword 0 = 0x1A2B3C4D and dword 2 = 0x06010000. Its base register 0 has size 0x100 and type 01, and its base register 1 has size 0x1000 and type 00. An implemented base register dword resets to its type bits; all other dwords reset to zero.
- R2: The address port is the dword at I/O address 0xCF8 and the data port is the dword at 0xCFC (`io_waddr` carries address bits 15:2). `io_be[n]` selects byte lane n, which is bits 8n+7:8n. Read data is the selected register masked to the enabled lanes. It is zero when `io_rd` is low or the address hits neither port.
- R3: Writes to lanes 0 to 2 of the address port only store the byte. Only a write with lane 3 enabled performs a lookup and updates the presence flag and the response.
- R4: The selector's bus is bits 23:16, its device/function byte is bits 15:8 and its dword index is bits 7:2. Bits 1:0 are ignored. The lookup matches the 16-bit value {bus, devfn} against the slot identifiers, and the lowest-numbered slot wins. On a match, the address port reads 0x80000000.
- R5: On a match, the response is the image dword at the index, or 0xFFFFFFFF when the index is at or beyond `IMG_DWORDS` (16).
- R6: When no slot matches, the address port reads 0 and the response is 0xFFFFFFFF.
- R7: Data-port reads return the response latched at the last lookup. A read never starts a lookup, and a later change to the image is not seen until the next lookup.
- R8: A data-port write has an effect only when lane 3 is enabled, the held selector matches a slot, and its index is 4 to 9 (offsets 0x10 to 0x27). Any other data-port write leaves every image unchanged.
- R9: For an implemented base register (number = index − 4), the new dword is built in three steps. The enabled write lanes are merged over the old dword. The result is ANDed with ~(size − 1). Bits 1:0 are then replaced by the type bits.
- R10: A qualifying write to a base register number that the slot does not implement clears that dword to zero.
- R11: Every port write takes effect at the clock edge on which it is presented. Read data is valid in the same cycle as `io_rd`, so a read in the cycle after a lookup already sees the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_waddr | input | ADDR_W-2 | Dword I/O address (bits ADDR_W-1:2) |
| io_be | input | 4 | Byte-lane enables |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, same cycle as io_rd |

## Verification
The hardest situations to reach are the ones where the latched response and the image disagree. This happens after a base-register write that was not followed by a new lookup, and after partial-lane writes that merge into a base register. The stimulus reaches them in three ways. It writes base registers and reads the data port before touching address lane 3. It then writes lane 3 alone to re-run the lookup on the unchanged selector. Finally, a lane-3-only data write checks that the other lanes keep their old bytes. Ignored writes (wrong index, no lane 3, selector that misses) are each followed by a fresh lookup, so any unwanted change would show at the data port.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int          WORD_W     = 32;
  localparam int          IDX_W      = 6;   // dword index field width
  localparam int          BAR_FIRST  = 4;   // index of first base register (offset 0x10)
  localparam int          BAR_SLOTS  = 6;   // base registers at indices 4..9
  localparam logic [31:0] ALL_ONES   = 32'hFFFF_FFFF;
  localparam logic [31:0] FOUND_WORD = 32'h8000_0000;

  typedef struct packed {
    logic        hit;
    logic [31:0] word;
  } look_t;

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++)
      m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] bar_fold(input logic [31:0] v,
                                           input logic [31:0] size,
                                           input logic [1:0]  typ);
    return (v & ~(size - 32'd1) & ~32'd3) | {30'd0, typ};
  endfunction
endpackage

// File: rtl/cfgp_bus_decode.sv
module cfgp_bus_decode #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] APORT_BASE = 16'h0CF8,
  parameter logic [ADDR_W-1:0] DPORT_BASE = 16'h0CFC
) (
  input  logic [ADDR_W-1:2] io_waddr,
  input  logic [3:0]        io_be,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [3:0]        aport_we,
  output logic [3:0]        dport_we,
  output logic              aport_re,
  output logic              dport_re
);
  logic hit_a, hit_d;

  assign hit_a    = (io_waddr == APORT_BASE[ADDR_W-1:2]);
  assign hit_d    = (io_waddr == DPORT_BASE[ADDR_W-1:2]);
  assign aport_we = (io_wr && hit_a) ? io_be : 4'b0000;
  assign dport_we = (io_wr && hit_d) ? io_be : 4'b0000;
  assign aport_re = io_rd && hit_a;
  assign dport_re = io_rd && hit_d;
endmodule

// File: rtl/cfgp_slot.sv
module cfgp_slot
  import cfgp_pkg::*;
#(
  parameter int                          IMG_DWORDS = 16,
  parameter int                          NUM_BARS   = 6,
  parameter logic [15:0]                 BDF        = 16'h0000,
  parameter logic [31:0]                 IDENT      = 32'h0,
  parameter logic [31:0]                 CLASSREV   = 32'h0,
  parameter logic [NUM_BARS-1:0][31:0]   SIZES      = '0,
  parameter logic [NUM_BARS-1:0][1:0]    TYPES      = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      look_bdf,
  input  logic [IDX_W-1:0] look_idx,
  output look_t            look,
  input  logic [15:0]      cur_bdf,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             wr_go,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data
);
  localparam int         AW  = $clog2(IMG_DWORDS);
  localparam logic [6:0] LIM = 7'(IMG_DWORDS);
  localparam int         BW  = 8;   // padded base-register table

  logic [31:0] img      [IMG_DWORDS];
  logic [31:0] init_img [IMG_DWORDS];

  // reset contents of each dword
  for (genvar g = 0; g < IMG_DWORDS; g++) begin : g_init
    if (g == 0) begin : g_ident
      assign init_img[g] = IDENT;
    end else if (g == 2) begin : g_class
      assign init_img[g] = CLASSREV;
    end else if (g >= BAR_FIRST && g < BAR_FIRST + NUM_BARS) begin : g_bar
      assign init_img[g] = (SIZES[g-BAR_FIRST] != 32'd0) ? {30'd0, TYPES[g-BAR_FIRST]} : 32'd0;
    end else begin : g_zero
      assign init_img[g] = 32'd0;
    end
  end

  // lookup read port
  logic look_in_img;
  assign look_in_img = ({1'b0, look_idx} < LIM);
  assign look.hit    = (look_bdf == BDF);
  assign look.word   = look_in_img ? img[look_idx[AW-1:0]] : ALL_ONES;

  // base register write path
  logic        cur_hit, bar_sel;
  logic [2:0]  bar_n;
  logic [31:0] merged, bar_next;
  logic [BW-1:0] bar_impl;
  logic [31:0]   bar_fold_v [BW];

  assign cur_hit = (cur_bdf == BDF);
  assign bar_sel = (cur_idx >= IDX_W'(BAR_FIRST)) && (cur_idx < IDX_W'(BAR_FIRST + BAR_SLOTS));
  assign bar_n   = 3'(cur_idx - IDX_W'(BAR_FIRST));
  assign merged  = merge_lanes(img[cur_idx[AW-1:0]], wr_data, wr_be);

  for (genvar b = 0; b < BW; b++) begin : g_bar_tab
    if (b < NUM_BARS) begin : g_real
      assign bar_impl[b]   = (SIZES[b] != 32'd0);
      assign bar_fold_v[b] = bar_fold(merged, SIZES[b], TYPES[b]);
    end else begin : g_none
      assign bar_impl[b]   = 1'b0;
      assign bar_fold_v[b] = 32'd0;
    end
  end

  assign bar_next = bar_impl[bar_n] ? bar_fold_v[bar_n] : 32'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < IMG_DWORDS; i++) img[i] <= init_img[i];
    end else if (wr_go && cur_hit && bar_sel) begin
      img[cur_idx[AW-1:0]] <= bar_next;
    end
  end
endmodule

// File: rtl/cfgp_pick.sv
module cfgp_pick
  import cfgp_pkg::*;
#(
  parameter int NUM_SLOTS = 2
) (
  input  look_t [NUM_SLOTS-1:0] looks,
  output look_t                 pick
);
  always_comb begin
    pick = '{hit: 1'b0, word: ALL_ONES};
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (looks[s].hit) pick = looks[s];
    end
  end
endmodule

// File: rtl/cfg_access_port.sv
module cfg_access_port
  import cfgp_pkg::*;
#(
  parameter int                                       NUM_SLOTS   = 2,
  parameter int                                       IMG_DWORDS  = 16,
  parameter int                                       NUM_BARS    = 6,
  parameter int                                       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]                        APORT_BASE  = 16'h0CF8,
  parameter logic [ADDR_W-1:0]                        DPORT_BASE  = 16'h0CFC,
  parameter logic [NUM_SLOTS-1:0][15:0]               SLOT_BDF    = {16'h0008, 16'h0000},
  parameter logic [NUM_SLOTS-1:0][31:0]               SLOT_IDENT  = {32'h1A2B_3C4D, 32'h5E6F_7081},
  parameter logic [NUM_SLOTS-1:0][31:0]               SLOT_CLASS  = {32'h0601_0000, 32'h0600_0001},
  parameter logic [NUM_SLOTS-1:0][NUM_BARS-1:0][31:0] SLOT_BAR_SZ = {{4{32'h0}}, 32'h0000_1000, 32'h0000_0100, {6{32'h0}}},
  parameter logic [NUM_SLOTS-1:0][NUM_BARS-1:0][1:0]  SLOT_BAR_TY = {8'h00, 2'b00, 2'b01, 12'h000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:2] io_waddr,
  input  logic [3:0]        io_be,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata
);
  logic [3:0]  aport_we, dport_we;
  logic        aport_re, dport_re;
  logic [23:2] addr_q, addr_nx;
  logic [31:0] rsp_q;
  logic        present_q;
  look_t [NUM_SLOTS-1:0] looks;
  look_t       pick;

  cfgp_bus_decode #(
    .ADDR_W(ADDR_W), .APORT_BASE(APORT_BASE), .DPORT_BASE(DPORT_BASE)
  ) u_dec (
    .io_waddr(io_waddr), .io_be(io_be), .io_wr(io_wr), .io_rd(io_rd),
    .aport_we(aport_we), .dport_we(dport_we),
    .aport_re(aport_re), .dport_re(dport_re)
  );

  // selector as it stands after this cycle's lane writes
  assign addr_nx[7:2]   = aport_we[0] ? io_wdata[7:2]   : addr_q[7:2];
  assign addr_nx[15:8]  = aport_we[1] ? io_wdata[15:8]  : addr_q[15:8];
  assign addr_nx[23:16] = aport_we[2] ? io_wdata[23:16] : addr_q[23:16];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    cfgp_slot #(
      .IMG_DWORDS(IMG_DWORDS), .NUM_BARS(NUM_BARS),
      .BDF(SLOT_BDF[s]), .IDENT(SLOT_IDENT[s]), .CLASSREV(SLOT_CLASS[s]),
      .SIZES(SLOT_BAR_SZ[s]), .TYPES(SLOT_BAR_TY[s])
    ) u_slot (
      .clk(clk), .rst(rst),
      .look_bdf(addr_nx[23:8]), .look_idx(addr_nx[7:2]), .look(looks[s]),
      .cur_bdf(addr_q[23:8]), .cur_idx(addr_q[7:2]),
      .wr_go(dport_we[3]), .wr_be(dport_we), .wr_data(io_wdata)
    );
  end

  cfgp_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (.looks(looks), .pick(pick));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      rsp_q     <= ALL_ONES;
      present_q <= 1'b0;
    end else begin
      addr_q <= addr_nx;
      if (aport_we[3]) begin
        present_q <= pick.hit;
        rsp_q     <= pick.hit ? pick.word : ALL_ONES;
      end
    end
  end

  always_comb begin
    if (aport_re)      io_rdata = (present_q ? FOUND_WORD : 32'd0) & lane_mask(io_be);
    else if (dport_re) io_rdata = rsp_q & lane_mask(io_be);
    else               io_rdata = 32'd0;
  end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] APORT_BASE = 16'h0CF8,
  parameter logic [ADDR_W-1:0] DPORT_BASE = 16'h0CFC
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:2] io_waddr,
  input logic [3:0]        io_be,
  input logic              io_wr,
  input logic              io_rd,
  input logic [31:0]       io_rdata,
  input logic [31:0]       rsp_q,
  input logic              present_q
);
  logic a_hit, top_wr;
  assign a_hit  = (io_waddr == APORT_BASE[ADDR_W-1:2]);
  assign top_wr = io_wr && a_hit && io_be[3];

  AST_RSP_ONLY_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    !top_wr |=> $stable(rsp_q)); // R3

  AST_FLAG_ONLY_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    !top_wr |=> $stable(present_q)); // R7

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    !present_q |-> (rsp_q == 32'hFFFF_FFFF)); // R6

  AST_STATUS_TWO_VALUES: assert property (@(posedge clk) disable iff (rst)
    (io_rd && a_hit && io_be == 4'hF) |-> (io_rdata == 32'h0 || io_rdata == 32'h8000_0000)); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !io_rd |-> (io_rdata == 32'h0)); // R2

  AST_DATA_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_waddr == DPORT_BASE[ADDR_W-1:2] && io_be == 4'hF) |-> (io_rdata == rsp_q)); // R7
endmodule

bind cfg_access_port cfgp_checker #(
  .ADDR_W(ADDR_W), .APORT_BASE(APORT_BASE), .DPORT_BASE(DPORT_BASE)
) u_chk (
  .clk(clk), .rst(rst), .io_waddr(io_waddr), .io_be(io_be), .io_wr(io_wr),
  .io_rd(io_rd), .io_rdata(io_rdata), .rsp_q(rsp_q), .present_q(present_q)
);

// File: tb/cfg_access_port_test.sv
`timescale 1ns/1ps
module cfg_access_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:2] io_waddr = '0;
  logic [3:0]  io_be = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [15:0] AP = 16'h0CF8;
  localparam logic [15:0] DP = 16'h0CFC;

  always #2 clk = ~clk;

  cfg_access_port uut (
    .clk(clk), .rst(rst), .io_waddr(io_waddr), .io_be(io_be), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  // behavioural reference model
  logic [31:0] m_img [2][16];
  logic [31:0] m_sel;
  logic [31:0] m_rsp;
  bit          m_pres;
  logic [15:0] m_bdf [2] = '{16'h0000, 16'h0008};
  logic [31:0] m_size[2][6];
  logic [1:0]  m_type[2][6];

  task automatic model_reset();
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 16; i++) m_img[s][i] = 32'h0;
      for (int b = 0; b < 6; b++) begin m_size[s][b] = 0; m_type[s][b] = 0; end
    end
    m_img[0][0] = 32'h5E6F_7081; m_img[0][2] = 32'h0600_0001;
    m_img[1][0] = 32'h1A2B_3C4D; m_img[1][2] = 32'h0601_0000;
    m_size[1][0] = 32'h100;  m_type[1][0] = 2'b01;
    m_size[1][1] = 32'h1000; m_type[1][1] = 2'b00;
    m_img[1][4] = 32'h1;
    m_sel = 0; m_rsp = 32'hFFFF_FFFF; m_pres = 0;
  endtask

  function automatic int m_find(input logic [31:0] sel);
    for (int s = 0; s < 2; s++) if (sel[23:8] == m_bdf[s]) return s;
    return -1;
  endfunction

  function automatic logic [31:0] m_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  function automatic logic [31:0] m_read(input logic [15:0] a, input logic [3:0] be, input bit rd);
    if (!rd) return 0;
    if (a == AP) return (m_pres ? 32'h8000_0000 : 32'h0) & m_mask(be);
    if (a == DP) return m_rsp & m_mask(be);
    return 0;
  endfunction

  task automatic model_step(input logic [15:0] a, input logic [3:0] be, input bit wr, input logic [31:0] wd);
    int s, idx, b;
    logic [31:0] mg, mk;
    if (!wr) return;
    mk = m_mask(be);
    if (a == AP) begin
      m_sel = (m_sel & ~mk) | (wd & mk);
      if (be[3]) begin
        s = m_find(m_sel);
        idx = int'(m_sel[7:2]);
        m_pres = (s >= 0);
        m_rsp  = (s >= 0 && idx < 16) ? m_img[s][idx] : 32'hFFFF_FFFF;
      end
    end else if (a == DP && be[3]) begin
      s = m_find(m_sel);
      idx = int'(m_sel[7:2]);
      if (s >= 0 && idx >= 4 && idx <= 9) begin
        b  = idx - 4;
        mg = (m_img[s][idx] & ~mk) | (wd & mk);
        if (m_size[s][b] != 0)
          m_img[s][idx] = (mg & ~(m_size[s][b] - 1) & ~32'd3) | {30'd0, m_type[s][b]};
        else
          m_img[s][idx] = 32'h0;
      end
    end
  endtask

  task automatic op(input logic [15:0] a, input logic [3:0] be, input bit wr, input bit rd,
                    input logic [31:0] wd, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    io_waddr = a[15:2]; io_be = be; io_wr = wr; io_rd = rd; io_wdata = wd;
    #1;
    exp = m_read(a, be, rd);
    n_cmp++;
    if (io_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: addr=%h be=%b rdata=%h expected=%h", tag, a, be, io_rdata, exp);
    end
    @(posedge clk);
    model_step(a, be, wr, wd);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, got no end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    op(AP, 4'hF, 0, 1, 0, "R1");                 // status 0
    op(DP, 4'hF, 0, 1, 0, "R1");                 // response all ones
    op(16'h0080, 4'hF, 0, 1, 0, "R2");           // unmapped read
    op(AP, 4'hF, 0, 0, 0, "R2");                 // no strobe
    op(AP, 4'b0111, 1, 0, 32'h0000_0800, "R3");
    op(AP, 4'hF, 0, 1, 0, "R3");                 // no lookup yet
    op(DP, 4'hF, 0, 1, 0, "R3");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R3");
    op(AP, 4'hF, 0, 1, 0, "R4");                 // found
    op(DP, 4'hF, 0, 1, 0, "R11");                // next cycle sees dword 0
    op(DP, 4'b0010, 0, 1, 0, "R2");
    op(DP, 4'b1001, 1, 1, 0, "R2");              // read with no-op write lanes
    op(AP, 4'hF, 1, 0, 32'h8000_0808, "R5");
    op(DP, 4'hF, 0, 1, 0, "R5");                 // class dword
    op(AP, 4'hF, 1, 0, 32'h8000_0850, "R5");
    op(DP, 4'hF, 0, 1, 0, "R5");                 // beyond image
    op(AP, 4'hF, 0, 1, 0, "R5");
    op(AP, 4'hF, 1, 0, 32'h8001_0000, "R6");
    op(AP, 4'hF, 0, 1, 0, "R6");
    op(DP, 4'hF, 0, 1, 0, "R6");
    op(AP, 4'hF, 1, 0, 32'h8000_0003, "R4");     // slot 0, low bits ignored
    op(DP, 4'hF, 0, 1, 0, "R4");
    // base register 0 of slot 1
    op(AP, 4'hF, 1, 0, 32'h8000_0810, "R9");
    op(DP, 4'hF, 0, 1, 0, "R9");
    op(DP, 4'hF, 1, 0, 32'hFFFF_FFFF, "R9");
    op(DP, 4'hF, 0, 1, 0, "R7");                 // stale response
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R7");
    op(DP, 4'hF, 0, 1, 0, "R9");                 // FFFFFF01
    // base register 1, full then lane-3 only
    op(AP, 4'hF, 1, 0, 32'h8000_0814, "R9");
    op(DP, 4'hF, 1, 0, 32'hFFFF_FFFF, "R9");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R9");
    op(DP, 4'hF, 0, 1, 0, "R9");                 // FFFFF000
    op(DP, 4'b1000, 1, 0, 32'h12AB_CDEF, "R9");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R9");
    op(DP, 4'hF, 0, 1, 0, "R9");                 // 12FFF000
    // no lane 3: ignored
    op(DP, 4'b0111, 1, 0, 32'h0000_0000, "R8");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R8");
    op(DP, 4'hF, 0, 1, 0, "R8");
    // unimplemented base register 2 of slot 1 and 0 of slot 0
    op(AP, 4'hF, 1, 0, 32'h8000_0818, "R10");
    op(DP, 4'hF, 1, 0, 32'hABCD_1234, "R10");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R10");
    op(DP, 4'hF, 0, 1, 0, "R10");
    op(AP, 4'hF, 1, 0, 32'h8000_0010, "R10");
    op(DP, 4'hF, 1, 0, 32'h5555_5555, "R10");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R10");
    op(DP, 4'hF, 0, 1, 0, "R10");
    // writes outside base range and on a missing device
    op(AP, 4'hF, 1, 0, 32'h8000_0800, "R8");
    op(DP, 4'hF, 1, 0, 32'hDEAD_BEEF, "R8");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R8");
    op(DP, 4'hF, 0, 1, 0, "R8");
    op(AP, 4'hF, 1, 0, 32'h8000_0828, "R8");
    op(DP, 4'hF, 1, 0, 32'hDEAD_BEEF, "R8");
    op(AP, 4'b1000, 1, 0, 32'h8000_0000, "R8");
    op(DP, 4'hF, 0, 1, 0, "R8");
    op(AP, 4'hF, 1, 0, 32'h8001_0814, "R8");
    op(DP, 4'hF, 1, 0, 32'h0000_0000, "R8");
    op(AP, 4'hF, 1, 0, 32'h8000_0814, "R8");
    op(DP, 4'hF, 0, 1, 0, "R8");

    // mixed traffic, compared every cycle
    for (int k = 0; k < 500; k++) begin
      logic [15:0] a;
      logic [31:0] wd;
      logic [15:0] bdf;
      int pick;
      pick = $urandom_range(0, 9);
      a = (pick < 4) ? AP : (pick < 8) ? DP : 16'h0040;
      case ($urandom_range(0, 3))
        0: bdf = 16'h0000;
        1: bdf = 16'h0008;
        2: bdf = 16'h0010;
        default: bdf = 16'h0108;
      endcase
      wd = (a == AP) ? {8'h80, bdf, 2'b00, 6'($urandom_range(0, 20)) << 0, 2'b00} : $urandom;
      if (a == AP) wd[7:2] = 6'($urandom_range(0, 20));
      op(a, 4'($urandom_range(0, 15)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), wd, "R11");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule